// File: doc/BRIEF.md
# Serial FIFO Error and Sign-Extension Handler

This block sits between a serial shift engine and its data queues. On the receive side it takes each word the shifter assembles, strobed by `rx_strobe`, and writes it into an internal receive FIFO. When that FIFO is full, the word is dropped. On the transmit side it answers each slot request from the shifter. It pops the external transmit FIFO when that FIFO holds data, and otherwise supplies a fill word. The fill word comes either from a dedicated underrun-data input or from the most recently received word.

Receive overflow and transmit underrun are each set independently to be tolerated or fatal. A tolerated event only raises a sticky flag. A fatal event also moves the controller into a halted state, where serial traffic stops until the module-on control is cleared. Words read from the receive FIFO are formatted to the selected word length. With sign extension off, the upper unused bits are zero. With sign extension on, they copy the word's most significant bit.

The controller has three states:
- OFF: the module is disabled and all state is cleared.
- RUN: traffic is passed.
- HALT: traffic is stopped after a fatal error.

The transitions are:
- OFF to RUN on `mod_on` high.
- RUN to HALT on a fatal overflow or a fatal underrun.
- Any state to OFF on `mod_on` low.

Top module: `serfifo_guard`

## Requirements
- R1: After reset, and in any cycle after `mod_on` is sampled low, the controller is in OFF. A rising `mod_on` moves it to RUN at the next edge, so words are accepted only from the cycle after `mod_on` is first seen high.
- R2: In RUN with the receive FIFO not full, `rx_strobe` asserts `rx_wr_en` in the same cycle and stores `rx_word`. Stored words are read in arrival order. `rd_data` shows the head word, and `rd_en` removes it.
- R3: With `ovf_tolerate`=1 and the receive FIFO full, a strobed word is dropped (`rx_wr_en`=0), the stored words are unchanged, `ovf_flag` is set at the next edge, and `halt` stays 0.
- R4: With `ovf_tolerate`=0, a strobed word arriving when the receive FIFO is full sets `ovf_flag` and `halt` at the next edge. While halted, `rx_wr_en` and `tx_pop` stay 0, and reads of stored words still work.
- R5: In RUN, a `tx_req` while `tx_empty`=0 asserts `tx_pop` and drives `tx_word` = `tx_data`.
- R6: With `und_tolerate`=1, a `tx_req` while `tx_empty`=1 drives the fill word on `tx_word`, leaves `tx_pop` at 0, and sets `und_flag` at the next edge without halting. This repeats for every slot until `tx_empty` falls.
- R7: The fill word is `und_word` when `und_src_sel`=1. Otherwise it is the last word strobed in RUN, whether that word was stored or dropped. That last word is zero after OFF.
- R8: With `und_tolerate`=0, a `tx_req` while `tx_empty`=1 sets `und_flag` and `halt` at the next edge.
- R9: `wlen` selects the word length: 00 = 8-bit, 01 = 16-bit, 10 and 11 = 32-bit. Bits above the length read as 0 when `sext_en`=0, and as a copy of bit 7 or bit 15 when `sext_en`=1. A 32-bit word reads unchanged. `rd_data` is 0 while `rx_empty`=1.
- R10: `ovf_flag` and `und_flag` are sticky while `mod_on`=1. A cycle with `mod_on`=0 clears both flags, `halt`, the receive FIFO and the last received word by the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_on | input | 1 | Module on; low clears all state |
| wlen | input | 2 | Word length select (00 = 8, 01 = 16, 1x = 32) |
| ovf_tolerate | input | 1 | 1 = overflow tolerated, 0 = overflow fatal |
| und_tolerate | input | 1 | 1 = underrun tolerated, 0 = underrun fatal |
| und_src_sel | input | 1 | 1 = fill from `und_word`, 0 = fill from last received word |
| sext_en | input | 1 | Sign-extend read data |
| rx_word | input | 32 | Word from the shifter |
| rx_strobe | input | 1 | `rx_word` is valid |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Transmit FIFO head word |
| tx_req | input | 1 | Shifter needs the next word |
| und_word | input | 32 | Dedicated underrun fill word |
| rd_en | input | 1 | Remove the receive FIFO head |
| tx_word | output | 32 | Word for the shifter (0 unless in RUN) |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_wr_en | output | 1 | Receive FIFO write enable |
| rd_data | output | 32 | Formatted receive FIFO head |
| rx_empty | output | 1 | Receive FIFO empty |
| ovf_flag | output | 1 | Sticky overflow flag |
| und_flag | output | 1 | Sticky underrun flag |
| halt | output | 1 | Halted after a fatal error |

## Verification
The formatter is tried with a table of words that covers each word length with the sign bit set and clear, and with sign extension on and off. This separates masking from extension and separates the 8-bit case from the 16-bit case. The overflow path fills the FIFO and then strobes one more word, once in tolerated mode and once in fatal mode. Reading the queue back afterwards shows that the dropped word touched nothing. The underrun path alternates between the two fill sources. It then refills the transmit FIFO, which shows that the fill stops, and it checks that the last received word counts a dropped word and resets to zero when the module is turned off.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_RUN  = 2'b01,
        ST_HALT = 2'b10
    } sfg_state_e;

    localparam logic [1:0] WL_8  = 2'b00;
    localparam logic [1:0] WL_16 = 2'b01;
endpackage

// File: rtl/sfg_fifo.sv
module sfg_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == FULLC);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (do_wr && !do_rd) count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end
endmodule

// File: rtl/sfg_fmt.sv
module sfg_fmt
    import sfg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   wlen,
    input  logic         sext_en,
    input  logic         valid,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_comb begin
        if (!valid) begin
            dout = '0;
        end else begin
            unique case (wlen)
                WL_8:    dout = {{(W-8){sext_en & din[7]}}, din[7:0]};
                WL_16:   dout = {{(W-16){sext_en & din[15]}}, din[15:0]};
                default: dout = din;
            endcase
        end
    end
endmodule

// File: rtl/sfg_ctrl.sv
module sfg_ctrl
    import sfg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mod_on,
    input  logic         ovf_tolerate,
    input  logic         und_tolerate,
    input  logic         rx_strobe,
    input  logic [W-1:0] rx_word,
    input  logic         rx_full,
    input  logic         tx_req,
    input  logic         tx_empty,
    output logic         running,
    output logic         halt,
    output logic         ovf_flag,
    output logic         und_flag,
    output logic [W-1:0] last_rx
);
    sfg_state_e state, state_nx;
    logic ovf_evt, und_evt, fatal;

    assign ovf_evt = (state == ST_RUN) && rx_strobe && rx_full;
    assign und_evt = (state == ST_RUN) && tx_req && tx_empty;
    assign fatal   = (ovf_evt && !ovf_tolerate) || (und_evt && !und_tolerate);

    always_comb begin
        state_nx = state;
        if (!mod_on) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  state_nx = ST_RUN;
                ST_RUN:  state_nx = fatal ? ST_HALT : ST_RUN;
                ST_HALT: state_nx = ST_HALT;
                default: state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        running = 1'b0;
        halt    = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_RUN:  running = 1'b1;
            ST_HALT: halt = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            und_flag <= 1'b0;
            last_rx  <= '0;
        end else if (!mod_on) begin
            ovf_flag <= 1'b0;
            und_flag <= 1'b0;
            last_rx  <= '0;
        end else begin
            if (ovf_evt) ovf_flag <= 1'b1;
            if (und_evt) und_flag <= 1'b1;
            if (state == ST_RUN && rx_strobe) last_rx <= rx_word;
        end
    end
endmodule

// File: rtl/serfifo_guard.sv
module serfifo_guard
    import sfg_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mod_on,
    input  logic [1:0]   wlen,
    input  logic         ovf_tolerate,
    input  logic         und_tolerate,
    input  logic         und_src_sel,
    input  logic         sext_en,
    input  logic [W-1:0] rx_word,
    input  logic         rx_strobe,
    input  logic         tx_empty,
    input  logic [W-1:0] tx_data,
    input  logic         tx_req,
    input  logic [W-1:0] und_word,
    input  logic         rd_en,
    output logic [W-1:0] tx_word,
    output logic         tx_pop,
    output logic         rx_wr_en,
    output logic [W-1:0] rd_data,
    output logic         rx_empty,
    output logic         ovf_flag,
    output logic         und_flag,
    output logic         halt
);
    logic         running;
    logic         rx_full;
    logic [W-1:0] last_rx;
    logic [W-1:0] head;

    sfg_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_on       (mod_on),
        .ovf_tolerate (ovf_tolerate),
        .und_tolerate (und_tolerate),
        .rx_strobe    (rx_strobe),
        .rx_word      (rx_word),
        .rx_full      (rx_full),
        .tx_req       (tx_req),
        .tx_empty     (tx_empty),
        .running      (running),
        .halt         (halt),
        .ovf_flag     (ovf_flag),
        .und_flag     (und_flag),
        .last_rx      (last_rx)
    );

    assign rx_wr_en = running && rx_strobe && !rx_full;
    assign tx_pop   = running && tx_req && !tx_empty;

    always_comb begin
        if (!running)      tx_word = '0;
        else if (!tx_empty) tx_word = tx_data;
        else if (und_src_sel) tx_word = und_word;
        else               tx_word = last_rx;
    end

    sfg_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!mod_on),
        .wr_en   (rx_wr_en),
        .wr_data (rx_word),
        .rd_en   (rd_en && mod_on),
        .rd_data (head),
        .empty   (rx_empty),
        .full    (rx_full)
    );

    sfg_fmt #(.W(W)) u_fmt (
        .wlen    (wlen),
        .sext_en (sext_en),
        .valid   (!rx_empty),
        .din     (head),
        .dout    (rd_data)
    );
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker (
    input logic clk,
    input logic rst_n,
    input logic mod_on,
    input logic running,
    input logic rx_strobe,
    input logic rx_full,
    input logic ovf_tolerate,
    input logic und_tolerate,
    input logic tx_req,
    input logic tx_empty,
    input logic rx_wr_en,
    input logic tx_pop,
    input logic halt,
    input logic ovf_flag,
    input logic und_flag,
    input logic rx_empty
);
    a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_en |-> !rx_full);

    a_r4_fatal_ovf_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mod_on && rx_strobe && rx_full && !ovf_tolerate) |=> halt);

    a_r4_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!rx_wr_en && !tx_pop));

    a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    a_r8_fatal_und_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mod_on && tx_req && tx_empty && !und_tolerate) |=> halt);

    a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && mod_on) |=> ovf_flag);

    a_r10_sticky_und: assert property (@(posedge clk) disable iff (!rst_n)
        (und_flag && mod_on) |=> und_flag);

    a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_on |=> (!ovf_flag && !und_flag && !halt && rx_empty));
endmodule

bind serfifo_guard sfg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mod_on       (mod_on),
    .running      (running),
    .rx_strobe    (rx_strobe),
    .rx_full      (rx_full),
    .ovf_tolerate (ovf_tolerate),
    .und_tolerate (und_tolerate),
    .tx_req       (tx_req),
    .tx_empty     (tx_empty),
    .rx_wr_en     (rx_wr_en),
    .tx_pop       (tx_pop),
    .halt         (halt),
    .ovf_flag     (ovf_flag),
    .und_flag     (und_flag),
    .rx_empty     (rx_empty)
);

// File: tb/serfifo_guard_tb.sv
module serfifo_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // vector: {wlen[1:0], sext, raw[31:0], expected[31:0]}
    localparam logic [66:0] VEC [NV] = '{
        {2'b00, 1'b0, 32'h123456A5, 32'h000000A5},
        {2'b00, 1'b1, 32'h123456A5, 32'hFFFFFFA5},
        {2'b00, 1'b1, 32'h00000075, 32'h00000075},
        {2'b01, 1'b1, 32'h00008001, 32'hFFFF8001},
        {2'b01, 1'b0, 32'hABCD8001, 32'h00008001},
        {2'b01, 1'b1, 32'hFFFF7FFF, 32'h00007FFF},
        {2'b10, 1'b1, 32'h80000001, 32'h80000001},
        {2'b11, 1'b0, 32'hDEADBEEF, 32'hDEADBEEF}
    };

    logic clk = 1'b0, rst_n = 1'b0, mod_on = 1'b0;
    logic [1:0] wlen = 2'b10;
    logic ovf_tolerate = 1'b1, und_tolerate = 1'b1, und_src_sel = 1'b0, sext_en = 1'b0;
    logic [31:0] rx_word = '0, tx_data = '0, und_word = '0;
    logic rx_strobe = 1'b0, tx_empty = 1'b1, tx_req = 1'b0, rd_en = 1'b0;
    logic [31:0] tx_word, rd_data;
    logic tx_pop, rx_wr_en, rx_empty, ovf_flag, und_flag, halt;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serfifo_guard u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(logic [31:0] w);
        rx_word = w; rx_strobe = 1'b1;
        tick();
        rx_strobe = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic restart();
        mod_on = 1'b0; tick();
        mod_on = 1'b1; tick();
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1; tick();
        // R1 / R10 reset state
        chk("R1 halt at reset", {31'b0, halt}, 32'd0);
        chk("R10 flags at reset", {30'b0, ovf_flag, und_flag}, 32'd0);
        chk("R1 rx_empty at reset", {31'b0, rx_empty}, 32'd1);
        // R1 first cycle after mod_on rises: still OFF
        mod_on = 1'b1; rx_strobe = 1'b1; rx_word = 32'h11; #1;
        chk("R1 no write while OFF", {31'b0, rx_wr_en}, 32'd0);
        tick(); #1;
        chk("R1 write once RUN", {31'b0, rx_wr_en}, 32'd1);
        tick(); rx_strobe = 1'b0;
        chk("R2 head word", rd_data, 32'h11);
        pop();
        chk("R2 empty after pop", {31'b0, rx_empty}, 32'd1);

        // R9 format table
        for (int i = 0; i < NV; i++) begin
            wlen = VEC[i][66:65]; sext_en = VEC[i][64];
            push(VEC[i][63:32]);
            chk($sformatf("R9 vector %0d", i), rd_data, VEC[i][31:0]);
            pop();
        end
        chk("R9 zero when empty", rd_data, 32'd0);
        wlen = 2'b10; sext_en = 1'b0;

        // R3 tolerated overflow
        ovf_tolerate = 1'b1;
        for (int i = 0; i < 4; i++) push(32'hA0 + i);
        rx_word = 32'hA4; rx_strobe = 1'b1; #1;
        chk("R3 drop when full", {31'b0, rx_wr_en}, 32'd0);
        tick(); rx_strobe = 1'b0;
        chk("R3 ovf_flag set", {31'b0, ovf_flag}, 32'd1);
        chk("R3 no halt", {31'b0, halt}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            chk($sformatf("R2 order word %0d", i), rd_data, 32'hA0 + i);
            pop();
        end
        chk("R3 queue drained", {31'b0, rx_empty}, 32'd1);

        // R6 / R7 tolerated underrun
        und_tolerate = 1'b1; und_src_sel = 1'b0; tx_empty = 1'b1; tx_req = 1'b1; #1;
        chk("R7 fill from last rx (dropped word)", tx_word, 32'hA4);
        chk("R6 no pop when empty", {31'b0, tx_pop}, 32'd0);
        tick();
        chk("R6 und_flag set", {31'b0, und_flag}, 32'd1);
        chk("R6 no halt", {31'b0, halt}, 32'd0);
        und_src_sel = 1'b1; und_word = 32'h5555AAAA; #1;
        chk("R7 fill from register", tx_word, 32'h5555AAAA);
        tick();
        tx_empty = 1'b0; tx_data = 32'h77; #1;
        chk("R5 data word", tx_word, 32'h77);
        chk("R5 pop", {31'b0, tx_pop}, 32'd1);
        tick(); tx_req = 1'b0; tx_empty = 1'b1;
        chk("R10 flags sticky", {30'b0, ovf_flag, und_flag}, 32'd3);
        mod_on = 1'b0; tick();
        chk("R10 flags cleared", {30'b0, ovf_flag, und_flag}, 32'd0);
        mod_on = 1'b1; tick();

        // R4 fatal overflow
        ovf_tolerate = 1'b0;
        for (int i = 0; i < 4; i++) push(32'hB0 + i);
        push(32'hB4);
        chk("R4 halt", {31'b0, halt}, 32'd1);
        chk("R4 ovf_flag", {31'b0, ovf_flag}, 32'd1);
        pop();
        rx_word = 32'hC0; rx_strobe = 1'b1; tx_req = 1'b1; tx_empty = 1'b0; #1;
        chk("R4 no write in halt", {31'b0, rx_wr_en}, 32'd0);
        chk("R4 no pop in halt", {31'b0, tx_pop}, 32'd0);
        tick(); rx_strobe = 1'b0; tx_req = 1'b0; tx_empty = 1'b1;
        chk("R4 stored words readable", rd_data, 32'hB1);
        mod_on = 1'b0; tick();
        chk("R10 halt cleared", {31'b0, halt}, 32'd0);
        chk("R10 queue flushed", {31'b0, rx_empty}, 32'd1);
        mod_on = 1'b1; tick();

        // R8 fatal underrun, R7 last word zero after OFF
        und_tolerate = 1'b0; und_src_sel = 1'b0; tx_req = 1'b1; tx_empty = 1'b1; #1;
        chk("R7 last word zero after off", tx_word, 32'd0);
        tick(); tx_req = 1'b0;
        chk("R8 halt", {31'b0, halt}, 32'd1);
        chk("R8 und_flag", {31'b0, und_flag}, 32'd1);
        restart();
        chk("R10 running again", {31'b0, halt}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule